// File: doc/BRIEF.md
# Transition Delta Register Bank

This block watches 28 live status lines and keeps one sticky delta flag per line. A flag goes to 1 whenever its status line changes value, whether it rises or falls. Once set, it stays set until software clears it. Software sees the flags through a small 16-bit register port made of four consecutive word addresses. The port is a read strobe and a write strobe sharing a two-bit word address. Read data comes out registered, one cycle after the read strobe.

A single mode input selects how flags are cleared, and it may change at any time. In one setting, reading a word clears the flags that the read returned. In the other, writing a word clears the flags whose write-data bits are 1. A flag that is cleared stays at 0 until its status line moves again. A new transition never gets lost, even if it lands on the same cycle as a clear of that flag.

Top module: `delta_bank`

## Requirements
- R1: After reset, every flag is 0 and `rdata_o` reads 0.
- R2: A 0-to-1 change on `status_i[i]` sets flag i. The flag is visible to a read strobe issued two clock edges after the change is sampled.
- R3: A 1-to-0 change on `status_i[i]` also sets flag i.
- R4: Status lines that are already nonzero when reset is released produce no flag.
- R5: Packing, using 1-based delta numbers (delta k = `status_i[k-1]`). Word 0 returns deltas 28..25 in its bits 3:0. Word 1 returns deltas 24..17, word 2 returns 16..9 and word 3 returns 8..1, each in bits 7:0 with the highest-numbered delta in bit 7.
- R6: Bits 15:8 of every word, and bits 7:4 of word 0, always read 0.
- R7: With `clr_on_wr_i`=0 (clear on read), a read clears exactly the flags it returned. The clear takes effect at the same edge that loads `rdata_o`. Other words are left unchanged.
- R8: With `clr_on_wr_i`=0, writes have no effect on any flag.
- R9: With `clr_on_wr_i`=1 (clear on write), writing 1 to a bit of the addressed word clears that flag. Writing 0 leaves the flag unchanged.
- R10: With `clr_on_wr_i`=1, reads do not clear flags.
- R11: A cleared flag stays 0 while its status line holds steady.
- R12: If a new transition and a clear of the same flag take effect at the same edge, the flag ends up set.
- R13: The clear mode may be switched at run time between accesses, and the new mode applies from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_i | input | 28 | Live status lines, sampled each clock |
| clr_on_wr_i | input | 1 | Clear mode: 0 = clear on read, 1 = clear on write |
| rd_en_i | input | 1 | Read strobe for the word at `addr_i` |
| wr_en_i | input | 1 | Write strobe for the word at `addr_i` |
| addr_i | input | 2 | Word address |
| wdata_i | input | 16 | Write data, 1 bits request a clear in clear-on-write mode |
| rdata_o | output | 16 | Registered read data |

## Verification
The bench targets a transition that arrives on the very edge where the same flag is cleared. A design in which the clear wins would read 0 on the second read, where the flag should still be set.

It releases reset with the status lines nonzero. A design that compares against a zero history would report false deltas here.

It writes in clear-on-read mode and reads in clear-on-write mode. A design that ignored the mode would lose flags in both cases.

Patterns of walking bits, all ones and alternating bits check the word packing and the zeroed reserved bits. A design with swapped words or a stray reserved bit would return values that do not match.

// File: rtl/delta_bank.sv
module delta_bank #(
  parameter int NUM_FLAGS = 28,
  parameter int DATA_W    = 16,
  parameter int WORD_BITS = 8,
  localparam int NWORDS   = (NUM_FLAGS + WORD_BITS - 1) / WORD_BITS,
  localparam int ADDR_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] status_i,
  input  logic                 clr_on_wr_i,
  input  logic                 rd_en_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o
);
  localparam int PAD_W  = NWORDS * WORD_BITS;
  localparam int SLOTS  = 2 ** ADDR_W;

  logic [NUM_FLAGS-1:0] stat_q, stat_prev, flags, toggled, clr_mask;
  logic                 primed;
  logic [PAD_W-1:0]     flags_pad;
  logic [WORD_BITS-1:0] words [SLOTS];
  logic [WORD_BITS-1:0] word_sel, clr_word;
  logic                 unused_wdata_hi;

  assign flags_pad = PAD_W'(flags);
  assign toggled   = stat_q ^ stat_prev;

  for (genvar w = 0; w < SLOTS; w++) begin : g_word
    if (w < NWORDS) begin : g_live
      assign words[w] = flags_pad[(NWORDS-1-w)*WORD_BITS +: WORD_BITS];
    end else begin : g_empty
      assign words[w] = '0;
    end
  end

  assign word_sel = words[addr_i];

  assign clr_word = (rd_en_i && !clr_on_wr_i) ? word_sel :
                    (wr_en_i &&  clr_on_wr_i) ? wdata_i[WORD_BITS-1:0] :
                    '0;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_clr
    localparam int WI = NWORDS - 1 - i / WORD_BITS;
    assign clr_mask[i] = (addr_i == ADDR_W'(WI)) && clr_word[i % WORD_BITS];
  end

  assign unused_wdata_hi = ^wdata_i[DATA_W-1:WORD_BITS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q    <= '0;
      stat_prev <= '0;
      primed    <= 1'b0;
      flags     <= '0;
      rdata_o   <= '0;
    end else begin
      primed    <= 1'b1;
      stat_q    <= status_i;
      stat_prev <= primed ? stat_q : status_i;
      flags     <= (flags & ~clr_mask) | toggled;
      if (rd_en_i)
        rdata_o <= {{(DATA_W-WORD_BITS){1'b0}}, word_sel};
    end
  end
endmodule

module delta_bank_chk #(
  parameter int NUM_FLAGS = 28,
  parameter int DATA_W    = 16,
  parameter int WORD_BITS = 8,
  parameter int ADDR_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr_on_wr_i,
  input logic                 rd_en_i,
  input logic                 wr_en_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [DATA_W-1:0]    rdata_o,
  input logic [NUM_FLAGS-1:0] flags,
  input logic [NUM_FLAGS-1:0] toggled
);
  assert_resv_hi_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[DATA_W-1:WORD_BITS] == '0);

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (|toggled) |=> ((flags & $past(toggled)) == $past(toggled)));

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (toggled == '0 && !rd_en_i && !wr_en_i) |=> $stable(flags));

  assert_cor_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_on_wr_i && wr_en_i && !rd_en_i && toggled == '0) |=> $stable(flags));

  assert_cow_read_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_on_wr_i && rd_en_i && !wr_en_i && toggled == '0) |=> $stable(flags));

  assert_cor_clears_returned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_on_wr_i && rd_en_i && toggled == '0) |=>
      ($countones(flags) + $countones(rdata_o) == $past($countones(flags))));

  assert_cow_only_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_on_wr_i && wr_en_i && toggled == '0) |=> ((flags & ~$past(flags)) == '0));
endmodule

bind delta_bank delta_bank_chk #(
  .NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .WORD_BITS(WORD_BITS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_on_wr_i(clr_on_wr_i), .rd_en_i(rd_en_i),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .rdata_o(rdata_o), .flags(flags),
  .toggled(toggled)
);

// File: tb/sim_delta_bank.sv
module sim_delta_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] status_i = '0;
  logic        clr_on_wr_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  localparam logic [27:0] PATS [6] = '{
    28'h0000001, 28'h8000001, 28'hFFFFFFF, 28'h5A5A5A5, 28'h0F0F0F0, 28'h0000000
  };

  delta_bank u0 (
    .clk(clk), .rst_n(rst_n), .status_i(status_i), .clr_on_wr_i(clr_on_wr_i),
    .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired: actual=hang expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  function automatic logic [15:0] expw(input logic [27:0] v, input int a);
    case (a)
      0:       return {12'h000, v[27:24]};
      1:       return {8'h00, v[23:16]};
      2:       return {8'h00, v[15:8]};
      default: return {8'h00, v[7:0]};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    rd_en_i = 1'b1;
    addr_i  = 2'(a);
    @(negedge clk);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic wr(input int a, input logic [15:0] v);
    @(negedge clk);
    wr_en_i = 1'b1;
    addr_i  = 2'(a);
    wdata_i = v;
    @(negedge clk);
    wr_en_i = 1'b0;
    wdata_i = '0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [15:0] d;
    logic [27:0] prev;

    status_i = 28'h1234567;
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", rdata_o, 16'h0000);
    rst_n = 1'b1;
    settle();
    chk("R1 rdata after reset", rdata_o, 16'h0000);
    for (int w = 0; w < 4; w++) begin
      rd(w, d);
      chk("R4 no false delta after reset", d, 16'h0000);
    end

    prev = 28'h1234567;
    for (int p = 0; p < 6; p++) begin
      status_i = PATS[p];
      settle();
      for (int w = 0; w < 4; w++) begin
        rd(w, d);
        chk("R2 R3 R5 R6 pattern read", d, expw(prev ^ PATS[p], w));
      end
      repeat (5) @(negedge clk);
      for (int w = 0; w < 4; w++) begin
        rd(w, d);
        chk("R7 R11 cleared after read", d, 16'h0000);
      end
      prev = PATS[p];
    end

    status_i = 28'h00000FF;
    settle();
    wr(3, 16'hFFFF);
    rd(2, d);
    chk("R7 other word untouched", d, 16'h0000);
    rd(3, d);
    chk("R8 write ignored in read-clear mode", d, 16'h00FF);

    clr_on_wr_i = 1'b1;
    status_i = 28'h0000000;
    settle();
    rd(3, d);
    chk("R13 R10 read keeps flags", d, 16'h00FF);
    wr(3, 16'h000F);
    rd(3, d);
    chk("R9 write 1 clears write 0 keeps", d, 16'h00F0);
    rd(3, d);
    chk("R10 second read still set", d, 16'h00F0);
    wr(3, 16'h00F0);
    rd(3, d);
    chk("R9 remaining cleared", d, 16'h0000);

    clr_on_wr_i = 1'b0;
    status_i = 28'h0000001;
    settle();
    @(negedge clk);
    status_i = 28'h0000000;
    rd(3, d);
    chk("R12 first read sees flag", d, 16'h0001);
    rd(3, d);
    chk("R12 set wins over clear", d, 16'h0001);
    rd(3, d);
    chk("R12 then clears", d, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule